// File: doc/BRIEF.md
# Bitmask Machine Cycle Sequencer

This block is the multi-cycle control of a small processor. The instruction decoder presents one-hot command lines. The sequencer turns the offered command into a mask of the special machine cycles that the command needs. Each cycle bit is an OR across the command lines that use that cycle. The sequencer then walks the mask one clock at a time. Each step clears the lowest set bit (m & (m-1)), so the cycles always run in ascending bit order.

At any moment only the enable line of the lowest remaining bit is high, and the datapath node tied to that line does its work. The program counter hold output stays high for as long as the command is executing.

The command port uses a valid/ready handshake:
- A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is high only while the sequencer is idle. While it is low, the offer is simply not taken, and the upstream side holds or withdraws it.
- The sequencer never pushes back on a command whose mask is zero. Such a command completes at the edge that takes it.

Top module: `bitmask_cycle_seq`

## Requirements
- R1: With the default mapping, command line k selects this cycle mask, where bit i of the mask drives `cyc_en[i]`: k0 = 8'b00000000, k1 = 8'b00000001, k2 = 8'b00000011, k3 = 8'b00000101, k4 = 8'b00011000, k5 = 8'b10000001, k6 = 8'b11111111, k7 = 8'b01100100.
- R2: If several command lines are high together, the loaded mask is the bitwise OR of their individual masks.
- R3: `cmd_ready` is high exactly when the mask is empty. A command is taken on a rising edge with `cmd_valid` and `cmd_ready` both high. Its first cycle enable appears in the clock period right after that edge.
- R4: The set bits of the mask are visited one per clock, in ascending bit order. There are exactly as many enabled periods as the mask has set bits.
- R5: `cyc_en` has at most one bit set, and it is all zeros while the sequencer is idle.
- R6: `busy` and `pc_hold` are high in exactly the periods in which a cycle enable is high. Both fall at the same edge that clears the last mask bit.
- R7: While the sequencer is busy, `cmd_valid` and the command lines have no effect on the running sequence.
- R8: A command whose mask is all zeros never raises `busy` or `pc_hold`. `cmd_ready` is still high in the period after the edge that took it.
- R9: A synchronous active-high `rst` clears the mask and all cycle enables. After reset the block is idle with `cmd_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_line | input | N_CMD (8) | One-hot decoded command lines |
| cmd_valid | input | 1 | Start strobe; offers the command on `cmd_line` |
| cmd_ready | output | 1 | High while idle; a command is taken when valid and ready meet at an edge |
| cyc_en | output | N_CYC (8) | Registered one-hot enable of the active machine cycle |
| busy | output | 1 | High while cycles remain in the mask |
| pc_hold | output | 1 | Holds the program counter while a command executes |

## Verification
Assertions check these properties on every clock:
- `cyc_en` stays one-hot or zero.
- The stall and busy flags agree with the enable register.
- Each new enable sits above the previous one.
- An offer made while busy removes exactly one bit per clock and loads nothing.
- A zero mask never raises `busy`.
- Reset empties the block.

Some behaviour only the bench scenarios can show. These are the exact mask each command line maps to, the union formed by several lines, and the full ordered enable sequence per command. The bench also shows the exact period in which `cmd_ready` returns.

// File: rtl/bitmask_seq_pkg.sv
package bitmask_seq_pkg;
  localparam int DEF_CMD = 8;
  localparam int DEF_CYC = 8;

  // Row k is the cycle mask of command line k (row 7 in the top byte).
  localparam logic [DEF_CMD-1:0][DEF_CYC-1:0] DEF_MAP = {
    8'b01100100,  // k7
    8'b11111111,  // k6
    8'b10000001,  // k5
    8'b00011000,  // k4
    8'b00000101,  // k3
    8'b00000011,  // k2
    8'b00000001,  // k1
    8'b00000000   // k0
  };
endpackage

// File: rtl/cmd_mask_map.sv
module cmd_mask_map #(
  parameter int N_CMD = 8,
  parameter int N_CYC = 8,
  parameter logic [N_CMD-1:0][N_CYC-1:0] MAP = '0
) (
  input  logic [N_CMD-1:0] cmd_line,
  output logic [N_CYC-1:0] cyc_mask
);
  // Each cycle bit is an OR over every command line that needs that cycle.
  for (genvar j = 0; j < N_CYC; j++) begin : g_bit
    logic [N_CMD-1:0] users;
    for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
      assign users[i] = cmd_line[i] & MAP[i][j];
    end
    assign cyc_mask[j] = |users;
  end
endmodule

// File: rtl/low_bit_split.sv
module low_bit_split #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] lowest,
  output logic [W-1:0] remainder
);
  assign lowest    = vec & (~vec + W'(1));
  assign remainder = vec & (vec - W'(1));
endmodule

// File: rtl/bitmask_cycle_seq.sv
module bitmask_cycle_seq
  import bitmask_seq_pkg::*;
#(
  parameter int N_CMD = DEF_CMD,
  parameter int N_CYC = DEF_CYC,
  parameter logic [N_CMD-1:0][N_CYC-1:0] CMD_MAP = DEF_MAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CMD-1:0] cmd_line,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  output logic [N_CYC-1:0] cyc_en,
  output logic             busy,
  output logic             pc_hold
);
  localparam logic [N_CYC-1:0] EMPTY = '0;

  logic [N_CYC-1:0] mapped, mask_q, mask_d, en_q;
  logic [N_CYC-1:0] low_cur, rest_cur, low_nxt, rest_nxt;
  logic             idle;

  cmd_mask_map #(.N_CMD(N_CMD), .N_CYC(N_CYC), .MAP(CMD_MAP)) u_map (
    .cmd_line (cmd_line),
    .cyc_mask (mapped)
  );

  low_bit_split #(.W(N_CYC)) u_cur (
    .vec       (mask_q),
    .lowest    (low_cur),
    .remainder (rest_cur)
  );

  low_bit_split #(.W(N_CYC)) u_nxt (
    .vec       (mask_d),
    .lowest    (low_nxt),
    .remainder (rest_nxt)
  );

  assign idle = (mask_q == EMPTY);

  always_comb begin
    if (!idle)          mask_d = rest_cur;
    else if (cmd_valid) mask_d = mapped;
    else                mask_d = EMPTY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= EMPTY;
      en_q   <= EMPTY;
    end else begin
      mask_q <= mask_d;
      en_q   <= low_nxt;
    end
  end

  assign cmd_ready = idle;
  assign busy      = !idle;
  assign pc_hold   = |en_q;
  assign cyc_en    = en_q;

  // R5: one active cycle at most
  p_onehot_en_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cyc_en));

  // R6: stall and busy track the enable register
  p_hold_matches_r6: assert property (@(posedge clk) disable iff (rst)
    (pc_hold == busy) && (busy == (cyc_en != EMPTY)));

  // R4: each following enable sits at a higher bit
  p_ascending_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cyc_en == EMPTY) || (cyc_en > $past(cyc_en)));

  // R7: an offer while busy drops exactly one bit and loads nothing
  p_busy_ignores_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

  // R8: a zero mask does not start a sequence
  p_zero_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && mapped == EMPTY) |=> !busy && !pc_hold);

  // R9: reset empties the sequencer
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (cyc_en == EMPTY) && !busy && cmd_ready);

  logic unused_ok;
  assign unused_ok = ^{low_cur, rest_nxt};
endmodule

// File: tb/bitmask_cycle_seq_tb.sv
module bitmask_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NY = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cmd_line = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready, busy, pc_hold;
  logic [NY-1:0] cyc_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [NY-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmask_cycle_seq u_dut (
    .clk(clk), .rst(rst), .cmd_line(cmd_line), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cyc_en(cyc_en), .busy(busy), .pc_hold(pc_hold)
  );

  // Masks per command line as given in R1.
  function automatic logic [NY-1:0] row_mask(int k);
    case (k)
      1: return 8'b00000001;
      2: return 8'b00000011;
      3: return 8'b00000101;
      4: return 8'b00011000;
      5: return 8'b10000001;
      6: return 8'b11111111;
      7: return 8'b01100100;
      default: return 8'b00000000;
    endcase
  endfunction

  function automatic logic [NY-1:0] union_mask(logic [NC-1:0] lines);
    logic [NY-1:0] m = '0;
    for (int k = 0; k < NC; k++) if (lines[k]) m |= row_mask(k);
    return m;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: waits for an idle period, queues the expected enables, offers the command.
  task automatic issue(logic [NC-1:0] lines);
    logic [NY-1:0] m;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    m = union_mask(lines);
    for (int b = 0; b < NY; b++) if (m[b]) exp_q.push_back(NY'(1) << b);
    cmd_line  = lines;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_line  = '0;
    if (m == '0) begin
      // R8: zero mask, still idle right after the taking edge
      check(!busy && !pc_hold && cmd_ready, "R8", {busy, pc_hold, cmd_ready}, 3'b001);
    end
  endtask

  // Monitor: compares every enabled period with the head of the queue.
  always @(negedge clk) begin
    if (!rst && !done) begin
      // R6 / R3: flags against the enable lines
      check((busy == (cyc_en != 0)) && (pc_hold == busy) && (cmd_ready == !busy),
            "R6", {cyc_en, busy, pc_hold, cmd_ready}, {cyc_en, 3'b001});
      if (cyc_en != 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", cyc_en, 0);
        end else begin
          logic [NY-1:0] e;
          e = exp_q.pop_front();
          // R1 R2 R4 R5: exact one-hot enable in ascending order
          check(cyc_en == e, "R4", cyc_en, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(cyc_en == 0 && !busy && !pc_hold && cmd_ready, "R9",
          {cyc_en, busy, pc_hold, cmd_ready}, 11'b00000000001);
    rst = 1'b0;

    // R1 each line alone
    for (int k = 0; k < NC; k++) issue(NC'(1) << k);

    // R2 unions
    issue(8'b00011010);
    issue(8'b10110000);

    // R7 offer during busy is ignored
    issue(8'b00010000);
    cmd_line = 8'b01000000; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_line = '0;
    issue(8'b00000100);

    // R8 zero mask back-to-back, then R3 a following command
    issue(8'b00000001);
    issue(8'b00000001);
    issue(8'b00000010);

    // R9 reset mid-sequence
    issue(8'b01000000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(cyc_en == 0 && !busy && cmd_ready, "R9", {cyc_en, busy, cmd_ready}, 10'b0000000001);
    exp_q.delete();
    rst = 1'b0;
    issue(8'b00001000);

    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R4", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule